// File: doc/BRIEF.md
# Address-Window Bus Decoder with Width and Granularity Translation

This block is a purely combinational Wishbone decoder that connects one initiator port to a fixed set of subordinate ports. Each subordinate owns a contiguous range of initiator word addresses. The incoming word address picks at most one subordinate. Only that subordinate sees the cycle-valid strobe. Its read data and handshake outputs are steered back to the initiator. Strobe, write enable, write data, lock and burst hints go to every subordinate unchanged. Select lines go to every subordinate after the lane mapping of its mode.

Windows are laid out at elaboration time. They follow one another in index order. Each one spans 2^AW initiator words, where AW is that subordinate's address width. An optional per-subordinate alignment raises its base to the next multiple of 2^N words.

Two translation modes exist:
- **Dense** serves a subordinate of full bus width whose granularity is equal to or finer than the decoder's. Each initiator select bit is then repeated over the matching finer select bits.
- **Sparse** serves a subordinate whose data width equals its granularity and fits in one decoder lane. One narrow word is placed in the lowest lane of each initiator word.

Error, retry and stall are returned only from subordinates configured to have them. A subordinate with coarser granularity is rejected at elaboration, as is an illegal mode width, a response signal the decoder lacks, or a window past the address space.

Top module: `wb_xlate_decoder`

## Requirements
- R1: With default parameters, the windows start at word addresses 0 (64 words), 64 (16 words), 256 (32 words, aligned to 2^8) and 1024 (8 words, aligned to 2^10). Every other address maps to no subordinate.
- R2: `s_cyc[i]` is high only when `m_cyc` is high and `m_adr` lies in window i. At most one bit of `s_cyc` is ever high.
- R3: `s_adr[i]` equals `m_adr` minus the base of window i, kept to the low AW bits of that subordinate, with zeros above.
- R4: `s_stb`, `s_we`, `s_dat_w`, `s_lock`, `s_cti` and `s_bte` equal the matching initiator inputs at all times.
- R5: A dense subordinate of equal granularity gets `m_sel` in the low select bits of its `s_sel` entry and zeros above. Lane k of `m_dat_r` (bits 8k+7..8k) carries its data when `m_sel[k]` is high and is zero otherwise.
- R6: A dense subordinate of half granularity (ratio 2) gets `m_sel[k]` on both select bits 2k and 2k+1 of its 8-bit `s_sel` entry. Read lanes are masked as in R5.
- R7: A sparse subordinate gets `m_sel[0]` on bit 0 of its `s_sel` entry and zeros above. `m_dat_r` is its low 8 data bits, zero-extended, when `m_sel[0]` is high, and zero otherwise.
- R8: `m_ack` follows the decoded subordinate's `s_ack`. `m_err`, `m_rty` and `m_stall` follow it only if that subordinate has the signal: feature bit 0 is error, bit 1 is retry, bit 2 is stall. By default subordinate 0 has error only, subordinate 3 has all three, and the others have none. Otherwise these outputs are low. Read data is chosen by address, independent of `m_cyc`.
- R9: For an address in no window, all of `s_cyc` is low, and `m_ack`, `m_err`, `m_rty`, `m_stall` and `m_dat_r` are all zero, whatever the subordinates drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_adr | input | ADDR_W | Initiator word address |
| m_dat_w | input | DATA_W | Initiator write data |
| m_dat_r | output | DATA_W | Read data returned to the initiator |
| m_sel | input | DATA_W/GRAN_W | Initiator lane selects |
| m_cyc | input | 1 | Initiator cycle valid |
| m_stb | input | 1 | Initiator strobe |
| m_we | input | 1 | Initiator write enable |
| m_ack | output | 1 | Acknowledge from decoded subordinate |
| m_err | output | 1 | Error from decoded subordinate |
| m_rty | output | 1 | Retry from decoded subordinate |
| m_stall | output | 1 | Stall from decoded subordinate |
| m_lock | input | 1 | Initiator lock request |
| m_cti | input | 3 | Initiator cycle type hint |
| m_bte | input | 2 | Initiator burst extension hint |
| s_adr | output | NSUB x ADDR_W | Translated address per subordinate |
| s_dat_w | output | DATA_W | Broadcast write data |
| s_dat_r | input | NSUB x DATA_W | Read data per subordinate |
| s_sel | output | NSUB x SSEL_W | Mapped selects per subordinate |
| s_cyc | output | NSUB | Cycle valid per subordinate |
| s_stb | output | 1 | Broadcast strobe |
| s_we | output | 1 | Broadcast write enable |
| s_ack | input | NSUB | Acknowledge per subordinate |
| s_err | input | NSUB | Error per subordinate |
| s_rty | input | NSUB | Retry per subordinate |
| s_stall | input | NSUB | Stall per subordinate |
| s_lock | output | 1 | Broadcast lock |
| s_cti | output | 3 | Broadcast cycle type hint |
| s_bte | output | 2 | Broadcast burst extension hint |

## Verification
The assertions are combinational. They assume every input is at a known level once stimulus starts. They also assume a subordinate raises `s_ack` only while its own `s_cyc` is high, which the acknowledge-source property depends on. The bench's subordinate models derive acknowledge from their own cycle-valid and strobe, and produce read data as a fixed function of their translated address. Error, retry and stall are driven high deliberately only around addresses where their effect, or their suppression for an unmapped address or a subordinate lacking the signal, is what is being checked.

// File: rtl/wb_xlate_pkg.sv
// Shared constants and helpers for the address-window decoder.
// Assumes feature masks are small integers with the bit meanings below.
package wb_xlate_pkg;

    localparam int unsigned FEAT_ERR   = 0;
    localparam int unsigned FEAT_RTY   = 1;
    localparam int unsigned FEAT_STALL = 2;

    // Round a word address up to the next multiple of 2**log2_align.
    function automatic int unsigned align_up(int unsigned value, int unsigned log2_align);
        int unsigned step;
        if (log2_align == 0) return value;
        step = 32'd1 << log2_align;
        return ((value + step - 1) / step) * step;
    endfunction

endpackage

// File: rtl/wb_xlate_window.sv
// Window match and address translation for one subordinate.
// Assumes BASE + 2**SPAN_LOG2 fits inside the ADDR_W word space.
module wb_xlate_window #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BASE      = 0,
    parameter int unsigned SPAN_LOG2 = 4
) (
    input  logic [ADDR_W-1:0] adr,
    output logic              hit,
    output logic [ADDR_W-1:0] sub_adr
);
    localparam logic [ADDR_W:0]   BASE_V = (ADDR_W + 1)'(BASE);
    localparam logic [ADDR_W-1:0] KEEP   = ADDR_W'((64'd1 << SPAN_LOG2) - 64'd1);

    logic [ADDR_W:0] diff;

    // Offset from the window base; the top bit is the borrow.
    assign diff = {1'b0, adr} - BASE_V;

    // Inside when no borrow and no offset bit above the span.
    assign hit = !diff[ADDR_W] && ((diff[ADDR_W-1:0] & ~KEEP) == '0);

    // Translated address keeps only the subordinate's own bits.
    assign sub_adr = diff[ADDR_W-1:0] & KEEP;

endmodule

// File: rtl/wb_xlate_lanes.sv
// Select expansion and read-lane assembly for one subordinate.
// Dense: full-width subordinate, granularity equal or finer by a power of two.
// Sparse: subordinate width equals its granularity and fits in one lane.
module wb_xlate_lanes #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned GRAN_W = 8,
    parameter int unsigned SSEL_W = 8,
    parameter int unsigned SUB_DW = 32,
    parameter int unsigned SUB_GW = 8,
    parameter int unsigned SPARSE = 0,
    localparam int unsigned SEL_W = DATA_W / GRAN_W
) (
    input  logic [SEL_W-1:0]  m_sel,
    input  logic [DATA_W-1:0] sub_rdata,
    output logic [SSEL_W-1:0] sub_sel,
    output logic [DATA_W-1:0] rdata
);
    if (SUB_GW > GRAN_W) begin : g_bad_gran
        $error("subordinate granularity coarser than decoder granularity");
    end

    if (SPARSE != 0) begin : g_sparse
        if (SUB_DW != SUB_GW || SUB_DW > GRAN_W) begin : g_bad_sparse
            $error("sparse subordinate width must equal its granularity and fit one lane");
        end
        logic unused_bits;

        // Upper selects and upper read bits carry nothing in this mode.
        assign unused_bits = ^{m_sel[SEL_W-1:1], sub_rdata[DATA_W-1:SUB_DW]};

        // Only the lowest lane reaches the narrow subordinate.
        assign sub_sel = SSEL_W'(m_sel[0]);

        // Narrow word returns zero-extended in lane 0.
        assign rdata = m_sel[0] ? DATA_W'(sub_rdata[SUB_DW-1:0]) : '0;
    end else begin : g_dense
        localparam int unsigned RATIO = GRAN_W / SUB_GW;
        if (SUB_DW != DATA_W || SEL_W * RATIO > SSEL_W) begin : g_bad_dense
            $error("dense subordinate must match the bus width and fit the select field");
        end

        // Each initiator select covers RATIO finer subordinate selects.
        for (genvar j = 0; j < SSEL_W; j++) begin : g_ssel
            if (j < SEL_W * RATIO) begin : g_used
                assign sub_sel[j] = m_sel[j / RATIO];
            end else begin : g_pad
                assign sub_sel[j] = 1'b0;
            end
        end

        // Unselected read lanes return zero.
        for (genvar k = 0; k < SEL_W; k++) begin : g_lane
            assign rdata[k*GRAN_W +: GRAN_W] = m_sel[k] ? sub_rdata[k*GRAN_W +: GRAN_W] : '0;
        end
    end

endmodule

// File: rtl/wb_xlate_respmux.sv
// Steers response and read data of the decoded subordinate to the initiator.
// Assumes hit is one-hot or zero; zero yields all-quiet outputs.
module wb_xlate_respmux #(
    parameter int unsigned NSUB   = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic [NSUB-1:0]             hit,
    input  logic [NSUB-1:0]             ack,
    input  logic [NSUB-1:0]             err,
    input  logic [NSUB-1:0]             rty,
    input  logic [NSUB-1:0]             stall,
    input  logic [NSUB-1:0][DATA_W-1:0] rdata,
    output logic                        o_ack,
    output logic                        o_err,
    output logic                        o_rty,
    output logic                        o_stall,
    output logic [DATA_W-1:0]           o_rdata
);
    // AND-OR selection across all windows.
    always_comb begin
        o_ack   = 1'b0;
        o_err   = 1'b0;
        o_rty   = 1'b0;
        o_stall = 1'b0;
        o_rdata = '0;
        for (int i = 0; i < NSUB; i++) begin
            o_ack   = o_ack   | (hit[i] & ack[i]);
            o_err   = o_err   | (hit[i] & err[i]);
            o_rty   = o_rty   | (hit[i] & rty[i]);
            o_stall = o_stall | (hit[i] & stall[i]);
            o_rdata = o_rdata | (rdata[i] & {DATA_W{hit[i]}});
        end
    end

endmodule

// File: rtl/wb_xlate_decoder.sv
// One-initiator, NSUB-subordinate combinational address decoder.
// Windows are placed in index order, each optionally aligned, each 2**AW words.
// Assumes decoder granularity divides the bus width and SEL_W > 1.
module wb_xlate_decoder #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned GRAN_W  = 8,
    parameter int unsigned NSUB    = 4,
    parameter int unsigned SSEL_W  = 8,
    parameter int unsigned SUB_AW     [NSUB] = '{6, 4, 5, 3},
    parameter int unsigned SUB_DW     [NSUB] = '{32, 32, 8, 32},
    parameter int unsigned SUB_GW     [NSUB] = '{8, 4, 8, 8},
    parameter int unsigned SUB_SPARSE [NSUB] = '{0, 0, 1, 0},
    parameter int unsigned SUB_ALIGN  [NSUB] = '{0, 0, 8, 10},
    parameter int unsigned SUB_FEAT   [NSUB] = '{1, 0, 0, 7},
    parameter int unsigned DEC_FEAT   = 7,
    localparam int unsigned SEL_W = DATA_W / GRAN_W
) (
    input  logic [ADDR_W-1:0]           m_adr,
    input  logic [DATA_W-1:0]           m_dat_w,
    output logic [DATA_W-1:0]           m_dat_r,
    input  logic [SEL_W-1:0]            m_sel,
    input  logic                        m_cyc,
    input  logic                        m_stb,
    input  logic                        m_we,
    output logic                        m_ack,
    output logic                        m_err,
    output logic                        m_rty,
    output logic                        m_stall,
    input  logic                        m_lock,
    input  logic [2:0]                  m_cti,
    input  logic [1:0]                  m_bte,
    output logic [NSUB-1:0][ADDR_W-1:0] s_adr,
    output logic [DATA_W-1:0]           s_dat_w,
    input  logic [NSUB-1:0][DATA_W-1:0] s_dat_r,
    output logic [NSUB-1:0][SSEL_W-1:0] s_sel,
    output logic [NSUB-1:0]             s_cyc,
    output logic                        s_stb,
    output logic                        s_we,
    input  logic [NSUB-1:0]             s_ack,
    input  logic [NSUB-1:0]             s_err,
    input  logic [NSUB-1:0]             s_rty,
    input  logic [NSUB-1:0]             s_stall,
    output logic                        s_lock,
    output logic [2:0]                  s_cti,
    output logic [1:0]                  s_bte
);
    import wb_xlate_pkg::*;

    localparam bit DEC_ERR   = ((DEC_FEAT >> FEAT_ERR) & 1) != 0;
    localparam bit DEC_RTY   = ((DEC_FEAT >> FEAT_RTY) & 1) != 0;
    localparam bit DEC_STALL = ((DEC_FEAT >> FEAT_STALL) & 1) != 0;

    // Base word address of window idx after sequential, aligned placement.
    function automatic int unsigned win_base(int unsigned idx);
        int unsigned nxt;
        int unsigned b;
        nxt = 0;
        b   = 0;
        for (int unsigned j = 0; j <= idx; j++) begin
            b   = align_up(nxt, SUB_ALIGN[j]);
            nxt = b + (32'd1 << SUB_AW[j]);
        end
        return b;
    endfunction

    logic [NSUB-1:0]             hit;
    logic [NSUB-1:0]             g_err;
    logic [NSUB-1:0]             g_rty;
    logic [NSUB-1:0]             g_stall;
    logic [NSUB-1:0][DATA_W-1:0] lane_rdata;
    logic                        mux_err;
    logic                        mux_rty;
    logic                        mux_stall;
    logic                        unused_resp;

    // Response inputs of subordinates lacking a feature are ignored.
    assign unused_resp = ^{s_err, s_rty, s_stall};

    for (genvar i = 0; i < NSUB; i++) begin : g_sub
        localparam int unsigned BASE      = win_base(i);
        localparam bit          HAS_ERR   = ((SUB_FEAT[i] >> FEAT_ERR) & 1) != 0;
        localparam bit          HAS_RTY   = ((SUB_FEAT[i] >> FEAT_RTY) & 1) != 0;
        localparam bit          HAS_STALL = ((SUB_FEAT[i] >> FEAT_STALL) & 1) != 0;

        if (64'(BASE) + (64'd1 << SUB_AW[i]) > (64'd1 << ADDR_W)) begin : g_bad_span
            $error("window runs past the initiator address space");
        end
        if ((SUB_FEAT[i] & ~DEC_FEAT) != 0) begin : g_bad_feat
            $error("subordinate response signal has no decoder counterpart");
        end

        wb_xlate_window #(
            .ADDR_W   (ADDR_W),
            .BASE     (BASE),
            .SPAN_LOG2(SUB_AW[i])
        ) u_window (
            .adr    (m_adr),
            .hit    (hit[i]),
            .sub_adr(s_adr[i])
        );

        wb_xlate_lanes #(
            .DATA_W(DATA_W),
            .GRAN_W(GRAN_W),
            .SSEL_W(SSEL_W),
            .SUB_DW(SUB_DW[i]),
            .SUB_GW(SUB_GW[i]),
            .SPARSE(SUB_SPARSE[i])
        ) u_lanes (
            .m_sel    (m_sel),
            .sub_rdata(s_dat_r[i]),
            .sub_sel  (s_sel[i]),
            .rdata    (lane_rdata[i])
        );

        // Cycle-valid reaches the decoded subordinate only.
        assign s_cyc[i] = m_cyc & hit[i];

        // Optional responses count only where the subordinate has them.
        assign g_err[i]   = HAS_ERR & s_err[i];
        assign g_rty[i]   = HAS_RTY & s_rty[i];
        assign g_stall[i] = HAS_STALL & s_stall[i];
    end

    wb_xlate_respmux #(
        .NSUB  (NSUB),
        .DATA_W(DATA_W)
    ) u_respmux (
        .hit    (hit),
        .ack    (s_ack),
        .err    (g_err),
        .rty    (g_rty),
        .stall  (g_stall),
        .rdata  (lane_rdata),
        .o_ack  (m_ack),
        .o_err  (mux_err),
        .o_rty  (mux_rty),
        .o_stall(mux_stall),
        .o_rdata(m_dat_r)
    );

    // Decoder-level presence of each optional response.
    assign m_err   = DEC_ERR & mux_err;
    assign m_rty   = DEC_RTY & mux_rty;
    assign m_stall = DEC_STALL & mux_stall;

    // Broadcast request fields.
    assign s_dat_w = m_dat_w;
    assign s_stb   = m_stb;
    assign s_we    = m_we;
    assign s_lock  = m_lock;
    assign s_cti   = m_cti;
    assign s_bte   = m_bte;

endmodule

// File: rtl/wb_xlate_decoder_chk.sv
// Combinational property checker for the decoder, attached by bind.
// Assumes inputs are known and a subordinate acks only under its own cyc.
module wb_xlate_decoder_chk #(
    parameter int unsigned NSUB   = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned GRAN_W = 8,
    localparam int unsigned SEL_W = DATA_W / GRAN_W
) (
    input logic              m_cyc,
    input logic [SEL_W-1:0]  m_sel,
    input logic              m_ack,
    input logic              m_err,
    input logic              m_rty,
    input logic              m_stall,
    input logic [DATA_W-1:0] m_dat_r,
    input logic [NSUB-1:0]   s_cyc,
    input logic [NSUB-1:0]   s_ack
);
    logic [DATA_W-1:0] sel_mask;

    // Bit mask of the read lanes the initiator selected.
    always_comb begin
        for (int k = 0; k < SEL_W; k++) begin
            sel_mask[k*GRAN_W +: GRAN_W] = {GRAN_W{m_sel[k]}};
        end
    end

    // Output relations that hold for every input combination.
    always_comb begin
        // R2
        cyc_onehot_chk: assert ($onehot0(s_cyc))
            else $error("more than one subordinate cycle-valid");
        // R2
        cyc_gate_chk: assert (m_cyc || (s_cyc == '0))
            else $error("subordinate cycle-valid without initiator cycle");
        // R9
        unmapped_quiet_chk: assert (!(m_cyc && (s_cyc == '0)) ||
                                    (!m_ack && !m_err && !m_rty && !m_stall && (m_dat_r == '0)))
            else $error("response seen for an unmapped address");
        // R8
        ack_source_chk: assert (!m_cyc || (m_ack == |(s_cyc & s_ack)))
            else $error("acknowledge not from the decoded subordinate");
        // R5
        lane_zero_chk: assert ((m_dat_r & ~sel_mask) == '0)
            else $error("unselected read lane not zero");
    end

endmodule

bind wb_xlate_decoder wb_xlate_decoder_chk #(
    .NSUB  (NSUB),
    .DATA_W(DATA_W),
    .GRAN_W(GRAN_W)
) u_chk (
    .m_cyc  (m_cyc),
    .m_sel  (m_sel),
    .m_ack  (m_ack),
    .m_err  (m_err),
    .m_rty  (m_rty),
    .m_stall(m_stall),
    .m_dat_r(m_dat_r),
    .s_cyc  (s_cyc),
    .s_ack  (s_ack)
);

// File: tb/test_wb_xlate_decoder.sv
// Scoreboard bench: the driver queues expected results, the monitor compares.
module test_wb_xlate_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    localparam int unsigned BASE [NS] = '{0, 64, 256, 1024};
    localparam int unsigned AWID [NS] = '{6, 4, 5, 3};
    localparam bit          F_ERR [NS] = '{1, 0, 0, 1};
    localparam bit          F_RTY [NS] = '{0, 0, 0, 1};
    localparam bit          F_STL [NS] = '{0, 0, 0, 1};

    typedef struct {
        string       tag;
        int          hit;
        logic [11:0] sadr;
        logic [3:0]  cyc;
        logic [31:0] ssel;
        logic [31:0] dat_r;
        logic        ack;
        logic        err;
        logic        rty;
        logic        stall;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [11:0]         m_adr = '0;
    logic [31:0]         m_dat_w = '0;
    logic [31:0]         m_dat_r;
    logic [3:0]          m_sel = '0;
    logic                m_cyc = 1'b0;
    logic                m_stb = 1'b0;
    logic                m_we = 1'b0;
    logic                m_ack, m_err, m_rty, m_stall;
    logic                m_lock = 1'b0;
    logic [2:0]          m_cti = '0;
    logic [1:0]          m_bte = '0;
    logic [NS-1:0][11:0] s_adr;
    logic [31:0]         s_dat_w;
    logic [NS-1:0][31:0] s_dat_r;
    logic [NS-1:0][7:0]  s_sel;
    logic [NS-1:0]       s_cyc;
    logic                s_stb, s_we, s_lock;
    logic [2:0]          s_cti;
    logic [1:0]          s_bte;
    logic [NS-1:0]       s_ack;
    logic [NS-1:0]       s_err = '0;
    logic [NS-1:0]       s_rty = '0;
    logic [NS-1:0]       s_stall = '0;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    exp_t cur;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wb_xlate_decoder i_wb_xlate_decoder (
        .m_adr(m_adr), .m_dat_w(m_dat_w), .m_dat_r(m_dat_r), .m_sel(m_sel),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_ack(m_ack), .m_err(m_err),
        .m_rty(m_rty), .m_stall(m_stall), .m_lock(m_lock), .m_cti(m_cti), .m_bte(m_bte),
        .s_adr(s_adr), .s_dat_w(s_dat_w), .s_dat_r(s_dat_r), .s_sel(s_sel),
        .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_ack(s_ack), .s_err(s_err),
        .s_rty(s_rty), .s_stall(s_stall), .s_lock(s_lock), .s_cti(s_cti), .s_bte(s_bte)
    );

    // Loopback subordinate word: byte k = low address byte + k + 16*index.
    function automatic logic [31:0] model_word(int i, logic [11:0] a);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[k*8 +: 8] = a[7:0] + 8'(k) + 8'(16 * i);
        return w;
    endfunction

    // Subordinate models: data from own address, ack from own cyc and stb.
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            s_dat_r[i] = model_word(i, s_adr[i]);
            s_ack[i]   = s_cyc[i] & s_stb;
        end
    end

    function automatic int find_sub(logic [11:0] a);
        for (int i = 0; i < NS; i++)
            if (a >= BASE[i] && a < BASE[i] + (32'd1 << AWID[i])) return i;
        return -1;
    endfunction

    function automatic logic [7:0] map_sel(int i, logic [3:0] sel);
        case (i)
            1:       return {sel[3], sel[3], sel[2], sel[2], sel[1], sel[1], sel[0], sel[0]};
            2:       return {7'b0, sel[0]};
            default: return {4'b0, sel};
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: apply one request and queue its expected outputs.
    task automatic drive(logic [11:0] adr, logic [3:0] sel, logic cyc,
                         logic [3:0] e, logic [3:0] r, logic [3:0] st, string tag);
        exp_t x;
        int   h;
        logic [31:0] w;
        @(posedge clk);
        #1;
        m_adr   = adr;
        m_sel   = sel;
        m_cyc   = cyc;
        m_stb   = 1'b1;
        m_we    = ~adr[1];
        m_dat_w = {8'hC3, adr[7:0], 4'h0, adr};
        m_lock  = adr[0];
        m_cti   = adr[2:0];
        m_bte   = adr[1:0];
        s_err   = e;
        s_rty   = r;
        s_stall = st;
        h = find_sub(adr);
        x.tag = tag;
        x.hit = h;
        x.cyc = '0;
        x.sadr = '0;
        x.dat_r = '0;
        x.ack = 1'b0;
        x.err = 1'b0;
        x.rty = 1'b0;
        x.stall = 1'b0;
        for (int i = 0; i < NS; i++) x.ssel[i*8 +: 8] = map_sel(i, sel);
        if (h >= 0) begin
            x.sadr = 12'((adr - 12'(BASE[h])) & 12'((32'd1 << AWID[h]) - 1));
            x.cyc[h] = cyc;
            w = model_word(h, x.sadr);
            if (h == 2) x.dat_r = sel[0] ? {24'b0, w[7:0]} : '0;
            else for (int k = 0; k < 4; k++) x.dat_r[k*8 +: 8] = sel[k] ? w[k*8 +: 8] : 8'h00;
            x.ack   = cyc;
            x.err   = F_ERR[h] & e[h];
            x.rty   = F_RTY[h] & r[h];
            x.stall = F_STL[h] & st[h];
        end
        sb_q.push_back(x);
    endtask

    // Monitor: compare away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            cur = sb_q.pop_front();
            check(s_cyc == cur.cyc, "R2", {cur.tag, " s_cyc"}, 32'(s_cyc), 32'(cur.cyc));
            check(32'(s_sel) == cur.ssel, cur.tag, "s_sel", 32'(s_sel), cur.ssel);
            check(m_dat_r == cur.dat_r, cur.tag, "m_dat_r", m_dat_r, cur.dat_r);
            check({m_ack, m_err, m_rty, m_stall} == {cur.ack, cur.err, cur.rty, cur.stall},
                  (cur.hit < 0) ? "R9" : "R8", {cur.tag, " ack/err/rty/stall"},
                  32'({m_ack, m_err, m_rty, m_stall}), 32'({cur.ack, cur.err, cur.rty, cur.stall}));
            if (cur.hit >= 0)
                check(s_adr[cur.hit] == cur.sadr, "R3", {cur.tag, " s_adr"},
                      32'(s_adr[cur.hit]), 32'(cur.sadr));
            check({s_dat_w, s_stb, s_we, s_lock, s_cti, s_bte} ==
                  {m_dat_w, m_stb, m_we, m_lock, m_cti, m_bte}, "R4", "broadcast fields",
                  s_dat_w ^ 32'({s_stb, s_we, s_lock, s_cti, s_bte}),
                  m_dat_w ^ 32'({m_stb, m_we, m_lock, m_cti, m_bte}));
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R2 reset state: no cycle, nothing to any subordinate
        drive(12'd5,    4'b0000, 1'b0, 4'h0, 4'h0, 4'h0, "R2 reset idle");
        drive(12'd5,    4'b1111, 1'b1, 4'h0, 4'h0, 4'h0, "R1/R5 sub0 full");
        drive(12'd63,   4'b0101, 1'b1, 4'h0, 4'h0, 4'h0, "R1/R5 sub0 top edge");
        drive(12'd64,   4'b1010, 1'b1, 4'h0, 4'h0, 4'h0, "R1/R6 sub1 base");
        drive(12'd79,   4'b1111, 1'b1, 4'h0, 4'h0, 4'h0, "R1/R6 sub1 top edge");
        drive(12'd80,   4'b1111, 1'b1, 4'hF, 4'hF, 4'hF, "R1/R9 gap after sub1");
        drive(12'd255,  4'b1111, 1'b1, 4'hF, 4'hF, 4'hF, "R1/R9 below align");
        drive(12'd256,  4'b1111, 1'b1, 4'h0, 4'h0, 4'h0, "R1/R7 sub2 base");
        drive(12'd265,  4'b0001, 1'b1, 4'h0, 4'h0, 4'h0, "R7 sub2 lane0");
        drive(12'd270,  4'b1110, 1'b1, 4'h0, 4'h0, 4'h0, "R7 sub2 no lane0");
        drive(12'd287,  4'b0011, 1'b1, 4'h0, 4'h0, 4'h0, "R1/R7 sub2 top edge");
        drive(12'd288,  4'b1111, 1'b1, 4'h0, 4'h0, 4'h0, "R1/R9 after sub2");
        drive(12'd1023, 4'b1111, 1'b1, 4'hF, 4'hF, 4'hF, "R1/R9 below sub3");
        drive(12'd1024, 4'b0110, 1'b1, 4'h0, 4'h0, 4'h0, "R1/R5 sub3 base");
        drive(12'd1031, 4'b1111, 1'b1, 4'h8, 4'h8, 4'h8, "R8 sub3 all resp");
        drive(12'd1027, 4'b1001, 1'b1, 4'h8, 4'h0, 4'h8, "R8 sub3 err+stall");
        drive(12'd1032, 4'b1111, 1'b1, 4'hF, 4'hF, 4'hF, "R1/R9 after sub3");
        drive(12'd4095, 4'b1111, 1'b1, 4'hF, 4'hF, 4'hF, "R9 top of space");
        drive(12'd10,   4'b1100, 1'b1, 4'h1, 4'h1, 4'h1, "R8 sub0 err only");
        drive(12'd70,   4'b0011, 1'b1, 4'h2, 4'h2, 4'h2, "R8/R6 sub1 no resp");
        drive(12'd20,   4'b1111, 1'b0, 4'h0, 4'h0, 4'h0, "R2/R8 sub0 no cycle");
        drive(12'd40,   4'b0000, 1'b1, 4'h0, 4'h0, 4'h0, "R5 sub0 no lanes");
        @(posedge clk);
        while (sb_q.size() != 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule